// File: doc/BRIEF.md
# Converter Command Channel Interface

This block sits between a serial arithmetic unit and a multiplexed analog conversion subsystem. The arithmetic unit writes a command word. The block keeps that word in channel 2 and uses its type field to choose the action. The action can be a digital-to-analog load, an analog-to-digital accumulation, a read of the discrete inputs, or a setting of the two thrust-derate annunciator lines. Channel 0 has two uses. It holds the value for a D/A load, and it is the X accumulator during an A/D run. Channel 1 is the Y accumulator. The converter is not modelled. It appears only as X and Y increment strobes and a done strobe.

Results go back to the arithmetic unit as a serial stream, most significant bit first, one bit per clock. An A/D result is the X word followed by the Y word. A discrete read sends only channel 0. The block also holds a small bank of failure-light flip-flops. Each light is set by its own strobe, and all of them are cleared by one clear input.

The control state machine has four states. `ST_IDLE` accepts commands. `ST_DA_LOAD` presents the D/A value for one cycle. `ST_AD_ACC` accumulates converter increments. `ST_SHIFT_OUT` streams the result.

Its transitions are:
- IDLE→DA_LOAD on an accepted D/A command.
- IDLE→AD_ACC on an accepted A/D command.
- IDLE→SHIFT_OUT on an accepted discrete read.
- IDLE→IDLE on an annunciator command or a rejected command.
- DA_LOAD→IDLE always.
- AD_ACC→SHIFT_OUT on the converter done strobe.
- SHIFT_OUT→IDLE after the last bit.

Top module: `cvt_chan_if`

## Requirements
- R1: Reset leaves the block in idle with `cmd_ready` high. `cmd_held`, `cmd_err`, `dac_load`, `ad_active`, `ad_ready`, `ser_valid`, `ser_last`, `derate` and `fail_lamp` are all zero.
- R2: The command word has three fields. Bits [1:0] are the type: 00 = D/A load, 01 = A/D run, 10 = discrete read, 11 = annunciator set. Bits [SEL_W+1:2] are the converter select. Every bit above the select is reserved and must be zero. An accepted command appears on `cmd_held` (channel 2) from the next cycle on.
- R3: A command with any reserved bit set is rejected. In the next cycle `cmd_err` is high, the block is still idle and `cmd_held` is unchanged. `cmd_err` stays high until the next command is accepted.
- R4: In the cycle after a D/A command is accepted, `dac_load` is high for exactly one cycle and `dac_value` equals the data given with the command. `cmd_ready` is low in that cycle.
- R5: An accepted A/D command clears both accumulators. `ad_active` is then high from the next cycle until the cycle that samples `adc_done`. While `ad_active` is high, no serial output and no D/A load occur.
- R6: During accumulation, each cycle with `inc_x` adds one to X and each cycle with `inc_y` adds one to Y. Both strobes may be high in the same cycle. Each accumulator saturates at all ones. Strobes outside accumulation have no effect.
- R7: `adc_done` ends accumulation. From the next cycle, `ad_ready` is high until the next accepted command, and X then Y are shifted out MSB first over 2*DW cycles. `ser_valid` is high in each of those cycles and `ser_last` is high on the final one.
- R8: A discrete read samples `disc_in` in the accepting cycle and zero-extends it into channel 0. It then shifts out DW bits MSB first, with `ser_last` on the last bit.
- R9: An annunciator command copies command bits [3:2] to `derate` and starts no other activity. `derate` changes on no other command.
- R10: A high `fail_set[i]` turns on `fail_lamp[i]` in the next cycle. The lamp stays on until `fail_clr`. If a set and a clear arrive in the same cycle, the set wins.
- R11: `cmd_valid` has no effect while `cmd_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command word offered |
| cmd_word | input | DW | Command word for channel 2 |
| cmd_data | input | DW | D/A value sent with a D/A command |
| cmd_ready | output | 1 | Idle, command can be taken |
| cmd_held | output | DW | Channel 2: last accepted command |
| cmd_err | output | 1 | Last offered command was rejected |
| dac_load | output | 1 | One-cycle D/A load strobe |
| dac_value | output | DW | Channel 0 value for the D/A |
| ad_active | output | 1 | A/D accumulation in progress |
| inc_x | input | 1 | Converter X increment strobe |
| inc_y | input | 1 | Converter Y increment strobe |
| adc_done | input | 1 | Converter end-of-conversion strobe |
| ad_ready | output | 1 | A/D result complete |
| ser_valid | output | 1 | Serial bit valid |
| ser_bit | output | 1 | Serial result bit |
| ser_last | output | 1 | Final bit of the stream |
| disc_in | input | NDISC | Level-converted discrete inputs |
| derate | output | 2 | Thrust-derate annunciator discretes |
| fail_set | input | NFAIL | Per-light failure set strobes |
| fail_clr | input | 1 | Clear all failure lights |
| fail_lamp | output | NFAIL | Failure-light flip-flops |

## Verification
The bench builds the block with DW=8, SEL_W=4, NDISC=5 and NFAIL=3. Word X reaches saturation after a run of 260 increments. Two reserved bits are enough to exercise rejection. The five discretes leave three high bits that show the zero-extension in the serial stream. A scoreboard queue holds the expected serial bits and the end-of-stream marks. Strobes and commands offered during a shift show whether the stream stays intact and the idle return is clean.

// File: rtl/cvt_pkg.sv
package cvt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_DA_LOAD   = 2'd1,
        ST_AD_ACC    = 2'd2,
        ST_SHIFT_OUT = 2'd3
    } cvt_state_e;

    typedef enum logic [1:0] {
        OP_DAC  = 2'b00,
        OP_ADC  = 2'b01,
        OP_DISC = 2'b10,
        OP_ANN  = 2'b11
    } cvt_op_e;

endpackage

// File: rtl/cvt_fsm.sv
module cvt_fsm
    import cvt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic       cmd_bad,
    input  cvt_op_e    op,
    input  logic       adc_done,
    input  logic       shift_done,
    output cvt_state_e state,
    output logic       accept,
    output logic       reject,
    output logic       cmd_ready,
    output logic       dac_load,
    output logic       ad_active,
    output logic       ser_valid
);

    cvt_state_e state_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (cmd_valid && !cmd_bad) begin
                    unique case (op)
                        OP_DAC:  state_nx = ST_DA_LOAD;
                        OP_ADC:  state_nx = ST_AD_ACC;
                        OP_DISC: state_nx = ST_SHIFT_OUT;
                        OP_ANN:  state_nx = ST_IDLE;
                    endcase
                end
            end
            ST_DA_LOAD:   state_nx = ST_IDLE;
            ST_AD_ACC:    if (adc_done)   state_nx = ST_SHIFT_OUT;
            ST_SHIFT_OUT: if (shift_done) state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cmd_ready = (state == ST_IDLE);
        accept    = (state == ST_IDLE) && cmd_valid && !cmd_bad;
        reject    = (state == ST_IDLE) && cmd_valid &&  cmd_bad;
        dac_load  = (state == ST_DA_LOAD);
        ad_active = (state == ST_AD_ACC);
        ser_valid = (state == ST_SHIFT_OUT);
    end

endmodule

// File: rtl/cvt_chan_regs.sv
module cvt_chan_regs
    import cvt_pkg::*;
#(
    parameter int DW    = 16,
    parameter int NDISC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cvt_state_e       state,
    input  logic             accept,
    input  logic             reject,
    input  cvt_op_e          op,
    input  logic [DW-1:0]    cmd_word,
    input  logic [DW-1:0]    cmd_data,
    input  logic [NDISC-1:0] disc_in,
    input  logic             inc_x,
    input  logic             inc_y,
    input  logic             adc_done,
    output logic [DW-1:0]    cmd_held,
    output logic [DW-1:0]    dac_value,
    output logic             ser_bit,
    output logic             ser_last,
    output logic             ad_ready,
    output logic             cmd_err
);

    localparam int CW = $clog2(2 * DW + 1);

    logic [DW-1:0] ch0_q;   // D/A value or X accumulator
    logic [DW-1:0] ch1_q;   // Y accumulator
    logic [DW-1:0] ch2_q;   // held command word
    logic [CW-1:0] bits_left_q;

    function automatic logic [DW-1:0] sat_step(input logic [DW-1:0] v, input logic en);
        if (en && (v != {DW{1'b1}})) return v + 1'b1;
        return v;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch0_q       <= '0;
            ch1_q       <= '0;
            ch2_q       <= '0;
            bits_left_q <= '0;
        end else if (accept) begin
            ch2_q <= cmd_word;
            unique case (op)
                OP_DAC:  ch0_q <= cmd_data;
                OP_ADC: begin
                    ch0_q <= '0;
                    ch1_q <= '0;
                end
                OP_DISC: begin
                    ch0_q       <= DW'(disc_in);
                    bits_left_q <= CW'(DW);
                end
                OP_ANN:  ;
            endcase
        end else if (state == ST_AD_ACC) begin
            ch0_q <= sat_step(ch0_q, inc_x);
            ch1_q <= sat_step(ch1_q, inc_y);
            if (adc_done) bits_left_q <= CW'(2 * DW);
        end else if (state == ST_SHIFT_OUT) begin
            ch0_q       <= {ch0_q[DW-2:0], ch1_q[DW-1]};
            ch1_q       <= {ch1_q[DW-2:0], 1'b0};
            bits_left_q <= bits_left_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ad_ready <= 1'b0;
            cmd_err  <= 1'b0;
        end else begin
            if (accept)
                ad_ready <= 1'b0;
            else if (state == ST_AD_ACC && adc_done)
                ad_ready <= 1'b1;
            if (accept)      cmd_err <= 1'b0;
            else if (reject) cmd_err <= 1'b1;
        end
    end

    always_comb begin
        cmd_held  = ch2_q;
        dac_value = ch0_q;
        ser_bit   = ch0_q[DW-1];
        ser_last  = (state == ST_SHIFT_OUT) && (bits_left_q == CW'(1));
    end

endmodule

// File: rtl/cvt_discretes.sv
module cvt_discretes #(
    parameter int NFAIL = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ann_load,
    input  logic [1:0]       ann_val,
    input  logic [NFAIL-1:0] fail_set,
    input  logic             fail_clr,
    output logic [1:0]       derate,
    output logic [NFAIL-1:0] fail_lamp
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        derate <= 2'b00;
        else if (ann_load) derate <= ann_val;
    end

    for (genvar i = 0; i < NFAIL; i++) begin : g_lamp
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           fail_lamp[i] <= 1'b0;
            else if (fail_set[i]) fail_lamp[i] <= 1'b1;
            else if (fail_clr)    fail_lamp[i] <= 1'b0;
        end
    end

endmodule

// File: rtl/cvt_chan_if.sv
module cvt_chan_if
    import cvt_pkg::*;
#(
    parameter int DW    = 16,
    parameter int SEL_W = 4,
    parameter int NDISC = 8,
    parameter int NFAIL = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [DW-1:0]    cmd_word,
    input  logic [DW-1:0]    cmd_data,
    output logic             cmd_ready,
    output logic [DW-1:0]    cmd_held,
    output logic             cmd_err,
    output logic             dac_load,
    output logic [DW-1:0]    dac_value,
    output logic             ad_active,
    input  logic             inc_x,
    input  logic             inc_y,
    input  logic             adc_done,
    output logic             ad_ready,
    output logic             ser_valid,
    output logic             ser_bit,
    output logic             ser_last,
    input  logic [NDISC-1:0] disc_in,
    output logic [1:0]       derate,
    input  logic [NFAIL-1:0] fail_set,
    input  logic             fail_clr,
    output logic [NFAIL-1:0] fail_lamp
);

    localparam int            RSV_LO   = SEL_W + 2;
    localparam logic [DW-1:0] RSV_MASK = {DW{1'b1}} << RSV_LO;

    cvt_state_e state;
    cvt_op_e    op;
    logic       cmd_bad;
    logic       accept;
    logic       reject;

    assign op      = cvt_op_e'(cmd_word[1:0]);
    assign cmd_bad = |(cmd_word & RSV_MASK);

    cvt_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_bad    (cmd_bad),
        .op         (op),
        .adc_done   (adc_done),
        .shift_done (ser_last),
        .state      (state),
        .accept     (accept),
        .reject     (reject),
        .cmd_ready  (cmd_ready),
        .dac_load   (dac_load),
        .ad_active  (ad_active),
        .ser_valid  (ser_valid)
    );

    cvt_chan_regs #(.DW(DW), .NDISC(NDISC)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .accept    (accept),
        .reject    (reject),
        .op        (op),
        .cmd_word  (cmd_word),
        .cmd_data  (cmd_data),
        .disc_in   (disc_in),
        .inc_x     (inc_x),
        .inc_y     (inc_y),
        .adc_done  (adc_done),
        .cmd_held  (cmd_held),
        .dac_value (dac_value),
        .ser_bit   (ser_bit),
        .ser_last  (ser_last),
        .ad_ready  (ad_ready),
        .cmd_err   (cmd_err)
    );

    cvt_discretes #(.NFAIL(NFAIL)) u_disc (
        .clk       (clk),
        .rst_n     (rst_n),
        .ann_load  (accept && (op == OP_ANN)),
        .ann_val   (cmd_word[3:2]),
        .fail_set  (fail_set),
        .fail_clr  (fail_clr),
        .derate    (derate),
        .fail_lamp (fail_lamp)
    );

endmodule

// File: rtl/cvt_chan_if_chk.sv
module cvt_chan_if_chk #(
    parameter int DW    = 16,
    parameter int SEL_W = 4,
    parameter int NFAIL = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic [DW-1:0]    cmd_word,
    input logic             cmd_ready,
    input logic             cmd_err,
    input logic             dac_load,
    input logic             ad_active,
    input logic             adc_done,
    input logic             ad_ready,
    input logic             ser_valid,
    input logic             ser_last,
    input logic [1:0]       derate,
    input logic [NFAIL-1:0] fail_set,
    input logic             fail_clr,
    input logic [NFAIL-1:0] fail_lamp
);

    localparam logic [DW-1:0] RSV_MASK = {DW{1'b1}} << (SEL_W + 2);

    // R3
    reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && ((cmd_word & RSV_MASK) != '0))
        |=> (cmd_err && cmd_ready && !ad_active && !ser_valid && !dac_load));

    // R4
    dac_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dac_load |=> (!dac_load && cmd_ready));

    // R5
    acc_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ad_active |-> (!ser_valid && !dac_load && !cmd_ready));

    // R7
    done_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ad_active && adc_done) |=> (ad_ready && ser_valid));

    // R7
    last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_last |-> ser_valid);

    // R7
    last_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_last |=> (!ser_valid && cmd_ready));

    // R9
    derate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && cmd_ready) |=> $stable(derate));

    // R10
    lamp_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|fail_set) |=> ((fail_lamp & $past(fail_set)) == $past(fail_set)));

    // R10
    lamp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fail_clr |=> ((fail_lamp & $past(fail_lamp)) == $past(fail_lamp)));

endmodule

bind cvt_chan_if cvt_chan_if_chk #(.DW(DW), .SEL_W(SEL_W), .NFAIL(NFAIL)) u_chk (.*);

// File: tb/sim_cvt_chan_if.sv
`timescale 1ns/1ps
module sim_cvt_chan_if;

    localparam int DW    = 8;
    localparam int SEL_W = 4;
    localparam int NDISC = 5;
    localparam int NFAIL = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_valid = 1'b0;
    logic [DW-1:0]    cmd_word = '0;
    logic [DW-1:0]    cmd_data = '0;
    logic             cmd_ready;
    logic [DW-1:0]    cmd_held;
    logic             cmd_err;
    logic             dac_load;
    logic [DW-1:0]    dac_value;
    logic             ad_active;
    logic             inc_x = 1'b0;
    logic             inc_y = 1'b0;
    logic             adc_done = 1'b0;
    logic             ad_ready;
    logic             ser_valid;
    logic             ser_bit;
    logic             ser_last;
    logic [NDISC-1:0] disc_in = '0;
    logic [1:0]       derate;
    logic [NFAIL-1:0] fail_set = '0;
    logic             fail_clr = 1'b0;
    logic [NFAIL-1:0] fail_lamp;

    int n_chk  = 0;
    int n_fail = 0;
    logic [1:0] exp_q[$];   // {last, bit}

    always #2 clk = ~clk;

    cvt_chan_if #(.DW(DW), .SEL_W(SEL_W), .NDISC(NDISC), .NFAIL(NFAIL)) u0 (.*);

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push_word(input logic [DW-1:0] v, input logic tail);
        for (int i = DW - 1; i >= 0; i--)
            exp_q.push_back({(tail && i == 0), v[i]});
    endtask

    task automatic send(input logic [DW-1:0] w, input logic [DW-1:0] d);
        cmd_word  = w;
        cmd_data  = d;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic pulse(input logic x, input logic y, input logic dn);
        inc_x = x; inc_y = y; adc_done = dn;
        @(negedge clk);
        inc_x = 1'b0; inc_y = 1'b0; adc_done = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (!cmd_ready);
    endtask

    // monitor: compares the serial stream against the scoreboard
    always @(negedge clk) begin
        if (rst_n && ser_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R7 unexpected serial bit", 32'(ser_bit), 32'hx);
            end else begin
                logic [1:0] e;
                e = exp_q.pop_front();
                chk(ser_bit == e[0], "R7 R8 serial bit", 32'(ser_bit), 32'(e[0]));
                chk(ser_last == e[1], "R7 R8 last flag", 32'(ser_last), 32'(e[1]));
            end
        end
    end

    task automatic finish_run();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #200000;
        chk(1'b0, "watchdog", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(cmd_ready == 1'b1, "R1 cmd_ready", 32'(cmd_ready), 32'd1);
        chk({cmd_held, cmd_err, dac_load, ad_active, ad_ready, ser_valid, ser_last, derate, fail_lamp} == '0,
            "R1 outputs zero", 32'({cmd_held, cmd_err, dac_load, ad_active, ad_ready, ser_valid, derate, fail_lamp}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 D/A load, select 5
        send({2'b00, 4'd5, 2'b00}, 8'hA5);
        chk(dac_load == 1'b1, "R4 dac_load", 32'(dac_load), 32'd1);
        chk(dac_value == 8'hA5, "R4 dac_value", 32'(dac_value), 32'hA5);
        chk(cmd_ready == 1'b0, "R4 busy", 32'(cmd_ready), 32'd0);
        chk(cmd_held == 8'h14, "R2 cmd_held", 32'(cmd_held), 32'h14);
        @(negedge clk);
        chk(dac_load == 1'b0 && cmd_ready, "R4 single pulse", 32'(dac_load), 32'd0);

        // R3 reserved bit set
        send(8'b0100_0001, 8'h00);
        chk(cmd_err == 1'b1, "R3 cmd_err", 32'(cmd_err), 32'd1);
        chk(cmd_ready && !ad_active, "R3 stays idle", 32'(ad_active), 32'd0);
        chk(cmd_held == 8'h14, "R3 held unchanged", 32'(cmd_held), 32'h14);

        // R5 R6 R7 A/D run, select 3
        send({2'b00, 4'd3, 2'b01}, 8'h00);
        chk(ad_active == 1'b1, "R5 ad_active", 32'(ad_active), 32'd1);
        chk(cmd_err == 1'b0, "R3 err cleared", 32'(cmd_err), 32'd0);
        pulse(1, 0, 0);
        pulse(1, 1, 0);
        pulse(0, 1, 0);
        pulse(1, 0, 0);
        pulse(0, 1, 0);
        pulse(1, 0, 0);
        push_word(8'd4, 1'b0);
        push_word(8'd3, 1'b1);
        pulse(0, 0, 1);
        chk(ad_ready == 1'b1, "R7 ad_ready", 32'(ad_ready), 32'd1);
        chk(ser_valid == 1'b1, "R7 shift start", 32'(ser_valid), 32'd1);
        // R6 R11 strobes and a command during the shift are ignored
        inc_x = 1'b1; inc_y = 1'b1;
        cmd_word = {2'b00, 4'd1, 2'b00}; cmd_data = 8'h3C; cmd_valid = 1'b1;
        repeat (5) @(negedge clk);
        inc_x = 1'b0; inc_y = 1'b0; cmd_valid = 1'b0;
        wait_idle();
        chk(ad_ready == 1'b1, "R11 no command taken", 32'(ad_ready), 32'd1);
        chk(cmd_held == 8'h0D, "R11 held unchanged", 32'(cmd_held), 32'h0D);
        chk(exp_q.size() == 0, "R7 stream complete", 32'(exp_q.size()), 32'd0);

        // R6 saturation
        send({2'b00, 4'd2, 2'b01}, 8'h00);
        inc_x = 1'b1;
        repeat (260) @(negedge clk);
        inc_x = 1'b0;
        push_word(8'hFF, 1'b0);
        push_word(8'h00, 1'b1);
        pulse(0, 0, 1);
        wait_idle();
        chk(exp_q.size() == 0, "R6 saturated stream", 32'(exp_q.size()), 32'd0);

        // R8 discrete read
        disc_in = 5'b10110;
        push_word(8'h16, 1'b1);
        send({2'b00, 4'd0, 2'b10}, 8'h00);
        disc_in = 5'b01001;
        chk(ad_ready == 1'b0, "R7 ready cleared", 32'(ad_ready), 32'd0);
        wait_idle();
        chk(exp_q.size() == 0, "R8 stream complete", 32'(exp_q.size()), 32'd0);

        // R9 annunciator
        send({2'b00, 4'b0010, 2'b11}, 8'h00);
        chk(derate == 2'b10, "R9 derate", 32'(derate), 32'h2);
        chk(cmd_ready && !ser_valid && !dac_load && !ad_active, "R9 no activity", 32'(cmd_ready), 32'd1);
        send({2'b00, 4'b1101, 2'b00}, 8'h11);
        @(negedge clk);
        chk(derate == 2'b10, "R9 unchanged by D/A", 32'(derate), 32'h2);

        // R10 failure lights
        fail_set = 3'b010; @(negedge clk); fail_set = '0;
        chk(fail_lamp == 3'b010, "R10 set", 32'(fail_lamp), 32'h2);
        fail_set = 3'b001; @(negedge clk); fail_set = '0;
        @(negedge clk);
        chk(fail_lamp == 3'b011, "R10 hold", 32'(fail_lamp), 32'h3);
        fail_set = 3'b100; fail_clr = 1'b1; @(negedge clk);
        fail_set = '0; fail_clr = 1'b0;
        chk(fail_lamp == 3'b100, "R10 set beats clear", 32'(fail_lamp), 32'h4);
        fail_clr = 1'b1; @(negedge clk); fail_clr = 1'b0;
        chk(fail_lamp == 3'b000, "R10 clear", 32'(fail_lamp), 32'h0);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule